// File: doc/BRIEF.md
# Operand Wakeup Station Array

This block buffers operations waiting in front of a single functional unit of an out-of-order core. At in-order issue an operation enters a free slot with an opcode and two source operands. Each source arrives either as a ready value or as the tag of the slot whose result it needs. While it waits, every slot watches a shared result bus that carries a data word and a source tag. A slot copies the data into any operand whose tag matches the one on the bus.

When the unit can take work, one fully ready slot is handed to it each cycle. The slot then stays reserved until its own tag appears on the result bus, and it is released on that edge. Slot tags run from 1 to the slot count. Tag 0 is reserved to mean that a value is present. The arithmetic unit and the arbitration of the result bus lie outside the block.

Top module: `rs_array`

## Requirements
- R1: After reset every slot is free, `iss_ready` is 1, `iss_tag` is 1 and `disp_valid` is 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) fills the lowest-index free slot. The slot at index i has tag i+1, and `iss_tag` shows this tag in the same cycle. Tag 0 is never given out.
- R3: When every slot is busy, `iss_ready` is 0. An issue attempt in that state is ignored and leaves the contents of all slots unchanged.
- R4: A source tag of 0 means the value field holds the operand. A waiting operand whose tag equals `cdb_tag` while `cdb_valid` is high takes `cdb_data` and counts as ready from the next cycle.
- R5: A slot is dispatched only when both operands hold values and `fu_free` is high. `disp_valid` and its fields are combinational and belong to the current cycle.
- R6: At most one slot is dispatched per cycle. Among ready slots the lowest index wins, even when it was issued later than a slot that is still waiting.
- R7: A dispatched slot stays busy until `cdb_valid` is high with its own tag. It is released on that edge and can be allocated from the next cycle.
- R8: When an issuing operand names the tag being broadcast in that same cycle, the slot stores the broadcast data in place of the tag.
- R9: The opcode and operand values presented at dispatch are those given at issue, with every tagged operand replaced by its producer's broadcast result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Opcode of the issuing operation |
| iss_vj | input | DW | First operand value, used when `iss_qj` is 0 |
| iss_qj | input | TW | Producer tag of the first operand, 0 if the value is present |
| iss_vk | input | DW | Second operand value, used when `iss_qk` is 0 |
| iss_qk | input | TW | Producer tag of the second operand, 0 if the value is present |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TW | Tag that an accepted issue receives this cycle |
| fu_free | input | 1 | Functional unit can accept an operation this cycle |
| disp_valid | output | 1 | An operation is handed to the unit this cycle |
| disp_tag | output | TW | Tag of the dispatched slot |
| disp_op | output | OPW | Opcode of the dispatched slot |
| disp_vj | output | DW | First operand value of the dispatched slot |
| disp_vk | output | DW | Second operand value of the dispatched slot |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TW | Tag of the slot that produced the result |
| cdb_data | input | DW | Result data |

## Verification
`iss_ready`, `iss_tag` and the dispatch outputs are combinational. The bench therefore reads them in the cycle that the stimulus is applied, one time unit after the falling edge and before the edge that acts on them. An operand woken by a broadcast can dispatch at the earliest in the cycle after that broadcast. A slot released by its broadcast is offered as `iss_tag` in the following cycle. Every directed check is placed at exactly those cycles. The bench's unit model returns each result on the bus three cycles after the dispatch cycle. A scoreboard keyed by tag matches every dispatch, whenever it comes, against the operands that the bench derived at issue time.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // widest tag any instance may use; tags are zero-extended to this for compares
  localparam int TAG_MAXW = 8;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,   // free for allocation
    SLOT_WAIT = 2'd1,   // holding operands, not yet handed to the unit
    SLOT_GONE = 2'd2    // handed to the unit, waiting for own result broadcast
  } slot_state_t;

  // a broadcast satisfies a pending operand when it is valid and tags agree;
  // tag zero never matches because it denotes a value already present
  function automatic logic tag_match(input logic                bus_vld,
                                     input logic [TAG_MAXW-1:0] bus_tag,
                                     input logic [TAG_MAXW-1:0] want);
    return bus_vld && (want != '0) && (bus_tag == want);
  endfunction

endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int N  = 4,
  parameter int TW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [TW-1:0] tag
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    tag   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        tag    = TW'(i + 1);
        found  = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DW     = 64,
  parameter int OPW    = 4,
  parameter int TW     = 3,
  parameter int MY_TAG = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_vj,
  input  logic [TW-1:0]  in_qj,
  input  logic [DW-1:0]  in_vk,
  input  logic [TW-1:0]  in_qk,
  input  logic           bc_valid,
  input  logic [TW-1:0]  bc_tag,
  input  logic [DW-1:0]  bc_data,
  input  logic           launch,
  output logic           busy,
  output logic           ready,
  output logic [OPW-1:0] op_o,
  output logic [DW-1:0]  vj_o,
  output logic [DW-1:0]  vk_o
);

  slot_state_t    st;
  logic [TW-1:0]  q_j, q_k;
  logic [DW-1:0]  v_j, v_k;
  logic [OPW-1:0] op_r;

  // wakeup and issue-cycle bypass events, named for visibility
  logic hit_j, hit_k, byp_j, byp_k, own_done;

  assign hit_j    = (st == SLOT_WAIT) && tag_match(bc_valid, TAG_MAXW'(bc_tag), TAG_MAXW'(q_j));
  assign hit_k    = (st == SLOT_WAIT) && tag_match(bc_valid, TAG_MAXW'(bc_tag), TAG_MAXW'(q_k));
  assign byp_j    = tag_match(bc_valid, TAG_MAXW'(bc_tag), TAG_MAXW'(in_qj));
  assign byp_k    = tag_match(bc_valid, TAG_MAXW'(bc_tag), TAG_MAXW'(in_qk));
  assign own_done = (st == SLOT_GONE) && bc_valid && (bc_tag == TW'(MY_TAG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SLOT_IDLE;
      q_j  <= '0;
      q_k  <= '0;
      v_j  <= '0;
      v_k  <= '0;
      op_r <= '0;
    end else if (alloc) begin
      st   <= SLOT_WAIT;
      op_r <= in_op;
      v_j  <= byp_j ? bc_data : in_vj;
      q_j  <= byp_j ? '0      : in_qj;
      v_k  <= byp_k ? bc_data : in_vk;
      q_k  <= byp_k ? '0      : in_qk;
    end else if (st == SLOT_WAIT) begin
      if (hit_j) begin
        v_j <= bc_data;
        q_j <= '0;
      end
      if (hit_k) begin
        v_k <= bc_data;
        q_k <= '0;
      end
      if (launch) st <= SLOT_GONE;
    end else if (own_done) begin
      st <= SLOT_IDLE;
    end
  end

  assign busy  = (st != SLOT_IDLE);
  assign ready = (st == SLOT_WAIT) && (q_j == '0) && (q_k == '0);
  assign op_o  = op_r;
  assign vj_o  = v_j;
  assign vk_o  = v_k;

endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int N_ENT = 4,
  parameter int DW    = 64,
  parameter int OPW   = 4,
  parameter int TW    = $clog2(N_ENT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [OPW-1:0] iss_op,
  input  logic [DW-1:0]  iss_vj,
  input  logic [TW-1:0]  iss_qj,
  input  logic [DW-1:0]  iss_vk,
  input  logic [TW-1:0]  iss_qk,
  output logic           iss_ready,
  output logic [TW-1:0]  iss_tag,
  input  logic           fu_free,
  output logic           disp_valid,
  output logic [TW-1:0]  disp_tag,
  output logic [OPW-1:0] disp_op,
  output logic [DW-1:0]  disp_vj,
  output logic [DW-1:0]  disp_vk,
  input  logic           cdb_valid,
  input  logic [TW-1:0]  cdb_tag,
  input  logic [DW-1:0]  cdb_data
);

  // named internal events, used by the bound checker
  logic [N_ENT-1:0] busy_vec;
  logic [N_ENT-1:0] rdy_vec;
  logic [N_ENT-1:0] free_gnt;
  logic [N_ENT-1:0] alloc_vec;
  logic [N_ENT-1:0] launch_vec;

  logic [OPW-1:0] ent_op [N_ENT];
  logic [DW-1:0]  ent_vj [N_ENT];
  logic [DW-1:0]  ent_vk [N_ENT];

  rs_prio_pick #(.N(N_ENT), .TW(TW)) u_alloc (
    .req (~busy_vec),
    .gnt (free_gnt),
    .any (iss_ready),
    .tag (iss_tag)
  );

  assign alloc_vec = free_gnt & {N_ENT{iss_valid}};

  rs_prio_pick #(.N(N_ENT), .TW(TW)) u_select (
    .req (rdy_vec & {N_ENT{fu_free}}),
    .gnt (launch_vec),
    .any (disp_valid),
    .tag (disp_tag)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    rs_entry #(.DW(DW), .OPW(OPW), .TW(TW), .MY_TAG(g + 1)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc_vec[g]),
      .in_op    (iss_op),
      .in_vj    (iss_vj),
      .in_qj    (iss_qj),
      .in_vk    (iss_vk),
      .in_qk    (iss_qk),
      .bc_valid (cdb_valid),
      .bc_tag   (cdb_tag),
      .bc_data  (cdb_data),
      .launch   (launch_vec[g]),
      .busy     (busy_vec[g]),
      .ready    (rdy_vec[g]),
      .op_o     (ent_op[g]),
      .vj_o     (ent_vj[g]),
      .vk_o     (ent_vk[g])
    );
  end

  // one-hot launch vector steers the selected slot onto the dispatch port
  always_comb begin
    disp_op = '0;
    disp_vj = '0;
    disp_vk = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (launch_vec[i]) begin
        disp_op = disp_op | ent_op[i];
        disp_vj = disp_vj | ent_vj[i];
        disp_vk = disp_vk | ent_vk[i];
      end
    end
  end

endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N_ENT = 4,
  parameter int TW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TW-1:0]    iss_tag,
  input logic             fu_free,
  input logic             disp_valid,
  input logic             cdb_valid,
  input logic [N_ENT-1:0] busy_vec,
  input logic [N_ENT-1:0] launch_vec
);

  // R2
  tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> (iss_tag != '0));

  // R3
  full_means_all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (&busy_vec));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

  // R5
  disp_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> fu_free);

  // R6
  single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_vec));

  // R7
  free_on_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(busy_vec) & ~busy_vec) != '0) |-> $past(cdb_valid));

endmodule

bind rs_array rs_array_chk #(.N_ENT(N_ENT), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_tag    (iss_tag),
  .fu_free    (fu_free),
  .disp_valid (disp_valid),
  .cdb_valid  (cdb_valid),
  .busy_vec   (busy_vec),
  .launch_vec (launch_vec)
);

// File: tb/sim_rs_array.sv
module sim_rs_array;
  localparam int N = 4, DW = 64, OPW = 4, TW = 3, LAT = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           iss_valid = 1'b0;
  logic [OPW-1:0] iss_op = '0;
  logic [DW-1:0]  iss_vj = '0, iss_vk = '0;
  logic [TW-1:0]  iss_qj = '0, iss_qk = '0;
  logic           iss_ready;
  logic [TW-1:0]  iss_tag;
  logic           fu_free = 1'b0;
  logic           disp_valid;
  logic [TW-1:0]  disp_tag;
  logic [OPW-1:0] disp_op;
  logic [DW-1:0]  disp_vj, disp_vk;
  logic           cdb_valid = 1'b0;
  logic [TW-1:0]  cdb_tag = '0;
  logic [DW-1:0]  cdb_data = '0;

  always #5 clk = ~clk;

  rs_array #(.N_ENT(N), .DW(DW), .OPW(OPW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
    .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .fu_free(fu_free), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [TW-1:0]  tag;
    logic [OPW-1:0] op;
    logic [DW-1:0]  a, b;
  } exp_t;
  exp_t exq[$];

  logic [DW-1:0] res_of [N+1];

  // unit model: fixed-latency pipe
  logic          pv [LAT];
  logic [TW-1:0] pt [LAT];
  logic [DW-1:0] pd [LAT];

  // staged inputs, applied at the falling edge
  logic           g_rst = 1'b0, g_iv = 1'b0, g_fu = 1'b0;
  logic [OPW-1:0] g_op = '0;
  logic [DW-1:0]  g_a = '0, g_b = '0;
  logic [TW-1:0]  g_qa = '0, g_qb = '0;

  // values sampled before the acting edge
  logic          s_ready, s_dv;
  logic [TW-1:0] s_tag, s_dtag;

  function automatic logic [DW-1:0] unit_fn(input logic [OPW-1:0] op,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a ^ b;
      default: return a & b;
    endcase
  endfunction

  task automatic check(input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cdb_valid = pv[LAT-1];
    cdb_tag   = pt[LAT-1];
    cdb_data  = pd[LAT-1];
    for (int i = LAT - 1; i > 0; i--) begin
      pv[i] = pv[i-1]; pt[i] = pt[i-1]; pd[i] = pd[i-1];
    end
    pv[0] = 1'b0;
    rst_n = g_rst; fu_free = g_fu; iss_valid = g_iv;
    iss_op = g_op; iss_vj = g_a; iss_qj = g_qa; iss_vk = g_b; iss_qk = g_qb;
    #1;
    s_ready = iss_ready; s_tag = iss_tag; s_dv = disp_valid; s_dtag = disp_tag;
    if (rst_n && disp_valid) begin
      pv[0] = 1'b1; pt[0] = disp_tag; pd[0] = unit_fn(disp_op, disp_vj, disp_vk);
    end
  endtask

  // driver: issue one operation, push its expected dispatch item
  task automatic issue(input logic [OPW-1:0] op, input logic [DW-1:0] a, input logic [TW-1:0] qa,
                       input logic [DW-1:0] b, input logic [TW-1:0] qb, output logic [TW-1:0] tag);
    logic [DW-1:0] ea, eb;
    ea = (qa != '0) ? res_of[qa] : a;
    eb = (qb != '0) ? res_of[qb] : b;
    g_iv = 1'b1; g_op = op; g_a = a; g_qa = qa; g_b = b; g_qb = qb;
    cycle();
    g_iv = 1'b0;
    if (s_ready) begin
      tag = s_tag;
      res_of[s_tag] = unit_fn(op, ea, eb);
      exq.push_back('{s_tag, op, ea, eb});
    end else begin
      tag = '0;
    end
  endtask

  // monitor: every dispatch must match an outstanding expected item (R9)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && disp_valid) begin
        int hit;
        hit = -1;
        for (int i = 0; i < exq.size(); i++)
          if (hit < 0 && exq[i].tag == disp_tag) hit = i;
        if (hit < 0) begin
          check("R9", "dispatch of unknown tag", 64'(disp_tag), 64'd0);
        end else begin
          check("R9", "dispatched opcode", 64'(disp_op), 64'(exq[hit].op));
          check("R9", "dispatched first operand", disp_vj, exq[hit].a);
          check("R9", "dispatched second operand", disp_vk, exq[hit].b);
          exq.delete(hit);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] t, tA, tB, tC, tD, tP, tQ;
    for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pt[i] = '0; pd[i] = '0; end
    for (int i = 0; i <= N; i++) res_of[i] = '0;

    repeat (3) cycle();
    g_rst = 1'b1; g_fu = 1'b1;
    cycle();
    check("R1", "iss_ready after reset", 64'(s_ready), 64'd1);
    check("R1", "iss_tag after reset", 64'(s_tag), 64'd1);
    check("R1", "disp_valid after reset", 64'(s_dv), 64'd0);

    // fill all slots with the unit stalled
    g_fu = 1'b0;
    issue(4'd0, 64'd1, '0, 64'd2, '0, t);  check("R2", "first tag", 64'(t), 64'd1);
    issue(4'd1, 64'd10, '0, 64'd3, '0, t); check("R2", "second tag", 64'(t), 64'd2);
    issue(4'd2, 64'd6, '0, 64'd5, '0, t);  check("R2", "third tag", 64'(t), 64'd3);
    issue(4'd3, 64'd12, '0, 64'd10, '0, t); check("R2", "fourth tag", 64'(t), 64'd4);
    cycle();
    check("R3", "iss_ready when full", 64'(s_ready), 64'd0);
    check("R5", "no dispatch while unit busy", 64'(s_dv), 64'd0);
    issue(4'd0, 64'd99, '0, 64'd99, '0, t);
    check("R3", "issue while full refused", 64'(t), 64'd0);

    // release the unit: lowest index first, one per cycle
    g_fu = 1'b1;
    cycle(); check("R6", "dispatch order 1", 64'(s_dtag), 64'd1);
    cycle(); check("R6", "dispatch order 2", 64'(s_dtag), 64'd2);
    cycle(); check("R6", "dispatch order 3", 64'(s_dtag), 64'd3);
    cycle(); check("R6", "dispatch order 4", 64'(s_dtag), 64'd4);
    check("R7", "slot held until own broadcast", 64'(s_ready), 64'd0);
    cycle();
    check("R7", "slot free after broadcast", 64'(s_ready), 64'd1);
    check("R7", "freed tag offered", 64'(s_tag), 64'd1);
    repeat (8) cycle();
    check("R3", "all items dispatched with issued operands", 64'(exq.size()), 64'd0);

    // dependency chain with out-of-order dispatch
    issue(4'd0, 64'd5, '0, 64'd7, '0, tA);
    check("R5", "nothing ready yet", 64'(s_dv), 64'd0);
    issue(4'd1, 64'd0, tA, 64'd10, '0, tB);
    check("R6", "producer dispatched", 64'(s_dtag), 64'(tA));
    issue(4'd2, 64'd0, tB, 64'd0, tA, tC);
    check("R5", "consumer waits for tag", 64'(s_dv), 64'd0);
    issue(4'd3, 64'hF0, '0, 64'h3C, '0, tD);
    check("R5", "no ready slot", 64'(s_dv), 64'd0);
    cycle();
    check("R6", "later ready slot goes first", 64'(s_dtag), 64'(tD));
    cycle();
    check("R4", "woken consumer dispatched", 64'(s_dtag), 64'(tB));
    check("R7", "producer slot reusable", 64'(s_tag), 64'(tA));
    repeat (12) cycle();
    check("R4", "whole chain resolved", 64'(exq.size()), 64'd0);
    check("R7", "all slots free again", 64'(s_tag), 64'd1);

    // issue in the very cycle the producer broadcasts
    issue(4'd0, 64'd100, '0, 64'd23, '0, tP);
    while (!(pv[LAT-1] && pt[LAT-1] == tP)) cycle();
    issue(4'd1, 64'd0, tP, 64'd3, '0, tQ);
    check("R2", "bypass consumer tag", 64'(tQ), 64'd2);
    cycle();
    check("R8", "bypassed operand ready next cycle", 64'(s_dv), 64'd1);
    check("R8", "bypassed slot dispatched", 64'(s_dtag), 64'(tQ));
    repeat (8) cycle();
    check("R8", "bypass items drained", 64'(exq.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule